// File: doc/BRIEF.md
# Cooling Fan Fault Supervisor with Power-Up Duty Selection

This block owns the duty register of a PWM-driven cooling fan and decides whether the fan has failed. When reset is released it loads a starting duty. That value comes from a duty kept across the last power cycle, if one is marked valid. If not, a board strap chooses between full drive and a reduced drive. After that, the host can write the duty at any time. The PWM generator reads the duty from `duty_out`.

Two separate conditions raise the fault flag. In the first, the fan is driven at full duty but its measured speed count stays below the target for a programmable number of one-second ticks. In the second, the fan reports that it has stopped while the duty is above a minimum value. Once raised, the flag stays set until the host clears it. Tachometer capture and waveform generation sit outside this block. The block receives a ready-made one-second tick pulse and a measured speed count in which larger means faster.

Top module: `fan_guard`

## Requirements
- R1: On the first clock edge after `rst_n` is released, if `kept_valid` is 1 and `duty_wr` is 0, `duty_out` takes the value of `kept_duty`. The new value is visible from the following cycle.
- R2: On that same first edge, if `kept_valid` is 0 and `duty_wr` is 0, the strap picks the duty. `strap_sel` = 0 loads 0xFF (full drive). `strap_sel` = 1 loads 0x66 (40 %, that is 102/255).
- R3: After the first edge following reset, changes on `kept_valid`, `kept_duty` and `strap_sel` have no effect on `duty_out`.
- R4: A cycle with `duty_wr` = 1 makes `duty_out` equal `duty_wdata` from the next cycle. This also applies on the first edge after reset, where the write takes priority over the power-up choice.
- R5: The fault-time register holds a 4-bit value N and allows a window of N+1 ticks. Its reset value is 10, which gives 11 ticks. A cycle with `ft_wr` = 1 loads `ft_wdata` into it.
- R6: The window counts only while `duty_out` is 0xFF and `tach_count` < `tach_target`, and it advances only in cycles where `tick_1s` is 1. `fault_out` rises in the cycle after the tick that completes N+1 counted ticks.
- R7: If `duty_out` leaves 0xFF, or if `tach_count` >= `tach_target`, for even a single cycle, the window count returns to zero. A later window then needs the full N+1 ticks again.
- R8: If `fan_stopped` = 1 and `duty_out` > `min_duty`, `fault_out` is set in the next cycle. If `duty_out` equals `min_duty`, this condition does not set the fault.
- R9: `fault_out` stays at 1 until a `fault_clr` pulse arrives in a cycle where no fault condition is active. It is then 0 in the next cycle. If a fault condition is active in the same cycle as the clear, the flag stays set.
- R10: While `rst_n` is 0, `duty_out` is 0x00 and `fault_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse once per second |
| duty_wr | input | 1 | Host duty write strobe |
| duty_wdata | input | 8 | Host duty write data |
| kept_valid | input | 1 | The retained duty is valid (sampled once after reset) |
| kept_duty | input | 8 | Duty retained across the last power cycle |
| strap_sel | input | 1 | Board strap: 0 gives full drive, 1 gives 40 % |
| ft_wr | input | 1 | Fault-time register write strobe |
| ft_wdata | input | 4 | Fault-time write data (window of N+1 seconds) |
| tach_count | input | 16 | Measured speed count, larger means faster |
| tach_target | input | 16 | Speed count the fan must reach |
| fan_stopped | input | 1 | The fan reports that it has stopped |
| min_duty | input | 8 | Duty above which a stopped fan is a fault |
| fault_clr | input | 1 | Write-one-to-clear strobe for the fault flag |
| duty_out | output | 8 | Current fan duty |
| fault_out | output | 1 | Sticky fault flag |

## Verification
The bench targets the off-by-one in the window. With the default field it expects silence after ten ticks and a fault on the eleventh, and with the field at 0 and at 15 it expects a fault on the first and the sixteenth tick. A design that reads N as N ticks would fault one tick early. The bench also pulls the fan up to target, or the duty away from full, for one cycle in the middle of a window. A counter that only paused instead of restarting would then fault early. The bench drives the stopped-fan case with the duty exactly at the minimum, where a `>=` comparison would wrongly fault. It also checks three ordering cases at power-up and clear time: a clear in the same cycle as an active fault condition, retained and strap inputs that change after the first cycle, and a host write on the first cycle after reset. Getting any of these orderings wrong leaves a visible wrong duty or a wrong flag.

// File: rtl/fan_guard_pkg.sv
package fan_guard_pkg;

  localparam int DUTY_W = 8;
  localparam int FT_W   = 4;
  localparam int WIN_W  = FT_W + 1;

  typedef logic [DUTY_W-1:0] duty_t;
  typedef logic [FT_W-1:0]   ftime_t;
  typedef logic [WIN_W-1:0]  win_t;

  localparam duty_t  DUTY_FULL = '1;
  // 40 % of full scale, rounded to nearest: 0.4 * 255 = 102
  localparam duty_t  DUTY_40   = duty_t'((2 * ((1 << DUTY_W) - 1) + 2) / 5);
  localparam ftime_t FT_RESET  = ftime_t'(10);

  // number of one-second ticks allowed by a fault-time field value
  function automatic win_t window_ticks(ftime_t ft);
    return win_t'(ft) + win_t'(1);
  endfunction

  // duty chosen at power-up when no host write is present
  function automatic duty_t boot_duty(logic valid, duty_t kept, logic strap);
    if (valid)      return kept;
    else if (strap) return DUTY_40;
    else            return DUTY_FULL;
  endfunction

endpackage

// File: rtl/fan_duty_reg.sv
module fan_duty_reg
  import fan_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  duty_t wdata,
  input  logic  kept_valid,
  input  duty_t kept_duty,
  input  logic  strap_sel,
  output duty_t duty,
  output logic  boot_load
);

  logic booted_q;

  assign boot_load = rst_n && !booted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      booted_q <= 1'b0;
      duty     <= '0;
    end else begin
      booted_q <= 1'b1;
      if (wr)             duty <= wdata;
      else if (boot_load) duty <= boot_duty(kept_valid, kept_duty, strap_sel);
    end
  end

endmodule

// File: rtl/fan_fault_window.sv
module fan_fault_window
  import fan_guard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             ft_wr,
  input  ftime_t           ft_wdata,
  input  duty_t            duty,
  input  logic [CNT_W-1:0] tach_count,
  input  logic [CNT_W-1:0] tach_target,
  output logic             run_en,
  output win_t             win_cnt,
  output logic             expire
);

  ftime_t ft_q;
  win_t   limit;
  win_t   next_cnt;
  logic   speed_ok;

  assign speed_ok = tach_count >= tach_target;
  assign run_en   = (duty == DUTY_FULL) && !speed_ok;
  assign limit    = window_ticks(ft_q);
  assign next_cnt = win_cnt + win_t'(1);
  assign expire   = run_en && sec_tick && (next_cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ft_q <= FT_RESET;
    else if (ft_wr) ft_q <= ft_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          win_cnt <= '0;
    else if (!run_en)                    win_cnt <= '0;
    else if (sec_tick && win_cnt < limit) win_cnt <= next_cnt;
  end

endmodule

// File: rtl/fan_fault_flag.sv
module fan_fault_flag
  import fan_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  expire,
  input  logic  fan_stopped,
  input  duty_t duty,
  input  duty_t min_duty,
  input  logic  clr,
  output logic  stop_hit,
  output logic  fault
);

  logic set_now;

  assign stop_hit = fan_stopped && (duty > min_duty);
  assign set_now  = expire || stop_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fault <= 1'b0;
    else if (set_now) fault <= 1'b1;
    else if (clr)     fault <= 1'b0;
  end

endmodule

// File: rtl/fan_guard.sv
module fan_guard
  import fan_guard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1s,
  input  logic             duty_wr,
  input  logic [7:0]       duty_wdata,
  input  logic             kept_valid,
  input  logic [7:0]       kept_duty,
  input  logic             strap_sel,
  input  logic             ft_wr,
  input  logic [3:0]       ft_wdata,
  input  logic [CNT_W-1:0] tach_count,
  input  logic [CNT_W-1:0] tach_target,
  input  logic             fan_stopped,
  input  logic [7:0]       min_duty,
  input  logic             fault_clr,
  output logic [7:0]       duty_out,
  output logic             fault_out
);

  duty_t duty_q;
  logic  boot_load;
  logic  run_en;
  win_t  win_cnt;
  logic  expire;
  logic  stop_hit;

  fan_duty_reg u_duty (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (duty_wr),
    .wdata      (duty_wdata),
    .kept_valid (kept_valid),
    .kept_duty  (kept_duty),
    .strap_sel  (strap_sel),
    .duty       (duty_q),
    .boot_load  (boot_load)
  );

  fan_fault_window #(.CNT_W(CNT_W)) u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (tick_1s),
    .ft_wr       (ft_wr),
    .ft_wdata    (ft_wdata),
    .duty        (duty_q),
    .tach_count  (tach_count),
    .tach_target (tach_target),
    .run_en      (run_en),
    .win_cnt     (win_cnt),
    .expire      (expire)
  );

  fan_fault_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire      (expire),
    .fan_stopped (fan_stopped),
    .duty        (duty_q),
    .min_duty    (min_duty),
    .clr         (fault_clr),
    .stop_hit    (stop_hit),
    .fault       (fault_out)
  );

  assign duty_out = duty_q;

endmodule

// File: rtl/fan_guard_chk.sv
module fan_guard_chk
  import fan_guard_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        tick_1s,
  input logic        duty_wr,
  input logic [7:0]  duty_wdata,
  input logic        kept_valid,
  input logic [7:0]  kept_duty,
  input logic        strap_sel,
  input logic        fault_clr,
  input logic [7:0]  duty_out,
  input logic        fault_out,
  input logic        boot_load,
  input logic        run_en,
  input logic [WIN_W-1:0] win_cnt,
  input logic        expire,
  input logic        stop_hit
);

  // R1
  boot_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_load && !duty_wr && kept_valid |=> duty_out == $past(kept_duty));

  // R2
  boot_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_load && !duty_wr && !kept_valid && !strap_sel |=> duty_out == 8'hFF);

  // R3
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_load && !duty_wr |=> $stable(duty_out));

  // R4
  duty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty_wr |=> duty_out == $past(duty_wdata));

  // R6
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !tick_1s |=> win_cnt == $past(win_cnt));

  // R6
  expire_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> fault_out);

  // R7
  window_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> win_cnt == '0);

  // R8
  stop_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> fault_out);

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_out && !fault_clr |=> fault_out);

  // R9
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_out && fault_clr && !expire && !stop_hit |=> !fault_out);

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (duty_out == 8'h00 && !fault_out);
    end
  end

endmodule

bind fan_guard fan_guard_chk i_fan_guard_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_1s    (tick_1s),
  .duty_wr    (duty_wr),
  .duty_wdata (duty_wdata),
  .kept_valid (kept_valid),
  .kept_duty  (kept_duty),
  .strap_sel  (strap_sel),
  .fault_clr  (fault_clr),
  .duty_out   (duty_out),
  .fault_out  (fault_out),
  .boot_load  (boot_load),
  .run_en     (run_en),
  .win_cnt    (win_cnt),
  .expire     (expire),
  .stop_hit   (stop_hit)
);

// File: tb/test_fan_guard.sv
`timescale 1ns/1ps
module test_fan_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1s = 1'b0;
  logic        duty_wr = 1'b0;
  logic [7:0]  duty_wdata = '0;
  logic        kept_valid = 1'b0;
  logic [7:0]  kept_duty = '0;
  logic        strap_sel = 1'b0;
  logic        ft_wr = 1'b0;
  logic [3:0]  ft_wdata = '0;
  logic [15:0] tach_count = '0;
  logic [15:0] tach_target = 16'd100;
  logic        fan_stopped = 1'b0;
  logic [7:0]  min_duty = '0;
  logic        fault_clr = 1'b0;
  logic [7:0]  duty_out;
  logic        fault_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fan_guard i_fan_guard (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .duty_wr(duty_wr),
    .duty_wdata(duty_wdata), .kept_valid(kept_valid), .kept_duty(kept_duty),
    .strap_sel(strap_sel), .ft_wr(ft_wr), .ft_wdata(ft_wdata),
    .tach_count(tach_count), .tach_target(tach_target),
    .fan_stopped(fan_stopped), .min_duty(min_duty), .fault_clr(fault_clr),
    .duty_out(duty_out), .fault_out(fault_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // window length restated from the requirement: field N allows N+1 ticks
  function automatic int ticks_for(input int n);
    return n + 1;
  endfunction

  task automatic do_reset(input logic v, input logic [7:0] kd, input logic s,
                          input logic wr, input logic [7:0] wd);
    @(negedge clk);
    rst_n = 1'b0; kept_valid = v; kept_duty = kd; strap_sel = s;
    tach_count = '0; tach_target = 16'd100; fan_stopped = 1'b0; min_duty = '0;
    fault_clr = 1'b0; tick_1s = 1'b0; ft_wr = 1'b0;
    duty_wr = wr; duty_wdata = wd;
    repeat (3) @(negedge clk);
    check("R10 duty in reset", duty_out, 8'h00);
    check("R10 fault in reset", fault_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    duty_wr = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick_1s = 1'b1;
    @(negedge clk) tick_1s = 1'b0;
  endtask

  task automatic host_duty(input logic [7:0] v);
    @(negedge clk) begin duty_wr = 1'b1; duty_wdata = v; end
    @(negedge clk) duty_wr = 1'b0;
    check("R4 host write", duty_out, v);
  endtask

  task automatic host_ft(input logic [3:0] v);
    @(negedge clk) begin ft_wr = 1'b1; ft_wdata = v; end
    @(negedge clk) ft_wr = 1'b0;
  endtask

  task automatic host_clear();
    @(negedge clk) fault_clr = 1'b1;
    @(negedge clk) fault_clr = 1'b0;
  endtask

  task automatic t_boot();
    do_reset(1'b1, 8'h5A, 1'b0, 1'b0, 8'h00);
    check("R1 retained duty loaded", duty_out, 8'h5A);
    do_reset(1'b0, 8'h5A, 1'b0, 1'b0, 8'h00);
    check("R2 strap 0 full drive", duty_out, 8'hFF);
    do_reset(1'b0, 8'h5A, 1'b1, 1'b0, 8'h00);
    check("R2 strap 1 forty percent", duty_out, 8'h66);
    do_reset(1'b1, 8'h5A, 1'b1, 1'b1, 8'h21);
    check("R4 write beats boot choice", duty_out, 8'h21);
  endtask

  task automatic t_boot_ignore();
    do_reset(1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
    kept_valid = 1'b1; kept_duty = 8'h11; strap_sel = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 late retained and strap ignored", duty_out, 8'h66);
    host_duty(8'h80);
    host_duty(8'hFF);
  endtask

  task automatic t_default_window();
    do_reset(1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < ticks_for(10) - 1; i++) begin
      pulse_tick();
      repeat (3) @(negedge clk);
    end
    check("R5 no fault after 10 ticks at reset field", fault_out, 0);
    repeat (20) @(negedge clk);
    check("R6 no count without ticks", fault_out, 0);
    pulse_tick();
    check("R5 fault on 11th tick", fault_out, 1);
  endtask

  task automatic t_restart();
    // target met for one cycle mid-window
    do_reset(1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    repeat (6) pulse_tick();
    @(negedge clk) tach_count = 16'd200;
    @(negedge clk) tach_count = 16'd0;
    repeat (10) pulse_tick();
    check("R7 target met restarts window", fault_out, 0);
    pulse_tick();
    check("R7 fault after full window again", fault_out, 1);
    // duty leaves full for one cycle mid-window
    do_reset(1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    repeat (6) pulse_tick();
    host_duty(8'hFE);
    host_duty(8'hFF);
    repeat (10) pulse_tick();
    check("R7 duty drop restarts window", fault_out, 0);
    pulse_tick();
    check("R7 fault after restart", fault_out, 1);
    // fan at speed: no counting
    do_reset(1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    tach_count = 16'd100;
    repeat (20) pulse_tick();
    check("R6 no fault when target reached", fault_out, 0);
    // not at full drive: no counting
    host_duty(8'hF0);
    tach_count = 16'd0;
    repeat (20) pulse_tick();
    check("R6 no fault below full duty", fault_out, 0);
  endtask

  task automatic t_field_prog();
    do_reset(1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    host_ft(4'd0);
    pulse_tick();
    check("R5 field 0 faults on first tick", fault_out, 1);
    tach_count = 16'd200;
    host_clear();
    check("R9 clear with no condition", fault_out, 0);
    host_ft(4'd15);
    tach_count = 16'd0;
    for (int i = 0; i < ticks_for(15) - 1; i++) pulse_tick();
    check("R5 field 15 silent after 15 ticks", fault_out, 0);
    pulse_tick();
    check("R5 field 15 faults on 16th tick", fault_out, 1);
  endtask

  task automatic t_stop_and_sticky();
    do_reset(1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
    min_duty = 8'h66;
    @(negedge clk) fan_stopped = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 duty equal to min gives no fault", fault_out, 0);
    min_duty = 8'h65;
    @(negedge clk);
    check("R8 stopped above min faults", fault_out, 1);
    host_clear();
    check("R9 clear loses to active condition", fault_out, 1);
    fan_stopped = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 flag stays set", fault_out, 1);
    host_clear();
    check("R9 clear after condition gone", fault_out, 0);
    repeat (3) @(negedge clk);
    check("R9 stays clear", fault_out, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_boot();
    t_boot_ignore();
    t_default_window();
    t_restart();
    t_field_prog();
    t_stop_and_sticky();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule